// File: doc/BRIEF.md
# Erase-Before-Write Page Store

This block models a flash storage array as a translation layer sees it. Storage is split into erase blocks. Each erase block holds a fixed number of pages, and each page holds a fixed number of data words. A client issues one command at a time: read a page, program a page, or erase a whole block. Page data moves one word per cycle over a valid/ready stream. The write stream carries data into the array and the read stream carries data out.

The array keeps one written flag per page. A page can be programmed only while its flag is clear. The only way to clear the flag is to erase the page's block. Each block also has a wear counter that counts its erases. When the counter equals the endurance limit, the block is worn out and refuses every later command. Every command ends with a single done pulse that carries a status code. Address mapping and wear levelling belong to the layer above this block.

Block count, page count per block and words per page must be powers of two. Data contents are undefined after reset until the block is first erased.

Top module: `flash_array`

## Requirements
- R1: `cmd_ready` is high exactly while no command is in progress. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high, and its block and page are captured on that edge. The op encoding is 2'b00 read, 2'b01 program, and 2'b1x erase.
- R2: An accepted program to a page whose flag is clear takes exactly WORDS_PER_PAGE words over `wr_valid`/`wr_ready`. Words are taken in order, word 0 first, and a later read of that page returns them in the same order.
- R3: An accepted read streams the WORDS_PER_PAGE words of the page over `rd_valid`/`rd_ready`, word 0 first. While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` hold their values into the next cycle.
- R4: An erase sets every word of the addressed block to all ones and clears the written flag of every page in that block. Other blocks keep their data and flags.
- R5: A program to a page whose flag is set completes with status 2'b01. `wr_ready` never rises during that command, and the stored page is left unchanged.
- R6: Each accepted erase of a block that is not worn adds one to that block's wear count. The erase that brings the count to WEAR_LIMIT completes with status 2'b00. From then on the block is worn out.
- R7: Any command to a worn-out block completes with status 2'b10. It opens no data stream and changes no data, flag or count.
- R8: Each command produces exactly one done pulse of one cycle. Erase and rejected commands pulse in the cycle after acceptance. Read and program pulse in the cycle after their last word transfer. `done_status` is 2'b00 for success and never 2'b11 while `done` is high.
- R9: A new command may be accepted in the same cycle that `done` is high for the previous one. Each of the two commands then gets its own pulse and status.
- R10: After reset, `done` is low, no stream is open, every page flag is clear and every wear count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block is idle and will take a command |
| cmd_op | input | 2 | 00 read, 01 program, 1x erase |
| cmd_blk | input | $clog2(NUM_BLOCKS) | Target erase block |
| cmd_page | input | $clog2(PAGES_PER_BLK) | Target page within the block |
| wr_valid | input | 1 | Program data word present |
| wr_ready | output | 1 | Array takes a program word |
| wr_data | input | DATA_W | Program data word |
| rd_valid | output | 1 | Read data word present |
| rd_ready | input | 1 | Client takes the read word |
| rd_data | output | DATA_W | Read data word |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 00 OK, 01 page already written, 10 block worn out |

## Verification
Two functions can fall in the same cycle: the completion pulse of one command and the acceptance of the next. The bench holds `cmd_valid` high through the done cycle of an erase and points a read at the block that was just erased. It then judges that the erase reports its own OK pulse, and that the read streams all-ones data and ends with a second, separate pulse. Random traffic confined to a few pages per block makes rejected programs and worn-out blocks frequent. Each outcome is compared with a bench model of the data, the flags and the wear counts.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'b00,
    ST_REWRITE = 2'b01,
    ST_WORN    = 2'b10
  } flash_status_e;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'b00,
    FS_WRITE = 2'b01,
    FS_READ  = 2'b10
  } flash_state_e;
endpackage

// File: rtl/flash_page_store.sv
module flash_page_store #(
  parameter int NUM_BLOCKS     = 4,
  parameter int PAGES_PER_BLK  = 32,
  parameter int WORDS_PER_PAGE = 4,
  parameter int DATA_W         = 16,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int PG_W   = $clog2(PAGES_PER_BLK),
  localparam int WD_W   = $clog2(WORDS_PER_PAGE),
  localparam int NPAGES = NUM_BLOCKS * PAGES_PER_BLK,
  localparam int DEPTH  = NPAGES * WORDS_PER_PAGE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_en,
  input  logic [BLK_W-1:0]  erase_blk,
  input  logic              word_we,
  input  logic              mark_en,
  input  logic [BLK_W-1:0]  acc_blk,
  input  logic [PG_W-1:0]   acc_page,
  input  logic [WD_W-1:0]   acc_word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [BLK_W-1:0]  q_blk,
  input  logic [PG_W-1:0]   q_page,
  output logic              q_written
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [NPAGES-1:0] written_q;
  logic [BLK_W+PG_W+WD_W-1:0] waddr;
  logic [BLK_W+PG_W-1:0]      paddr;

  assign waddr = {acc_blk, acc_page, acc_word};
  assign paddr = {acc_blk, acc_page};

  // data array: erase fills a whole block with ones, program writes one word
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (erase_en && ((i >> (PG_W + WD_W)) == int'(erase_blk)))
        mem[i] <= '1;
      else if (word_we && (i == int'(waddr)))
        mem[i] <= wdata;
    end
  end

  // per-page written flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      written_q <= '0;
    end else begin
      for (int j = 0; j < NPAGES; j++) begin
        if (erase_en && ((j >> PG_W) == int'(erase_blk)))
          written_q[j] <= 1'b0;
        else if (mark_en && (j == int'(paddr)))
          written_q[j] <= 1'b1;
      end
    end
  end

  assign rdata     = mem[waddr];
  assign q_written = written_q[{q_blk, q_page}];
endmodule

// File: rtl/flash_wear_table.sv
module flash_wear_table #(
  parameter int NUM_BLOCKS = 4,
  parameter int WEAR_LIMIT = 100000,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int CNT_W = $clog2(WEAR_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [BLK_W-1:0] inc_blk,
  input  logic [BLK_W-1:0] q_blk,
  output logic             q_worn
);
  logic [NUM_BLOCKS-1:0] worn_vec;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_en;
    assign cnt_en = inc_en && (inc_blk == BLK_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_q + 1'b1;
    end
    assign worn_vec[b] = (cnt_q == CNT_W'(WEAR_LIMIT));
  end

  assign q_worn = worn_vec[q_blk];
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int NUM_BLOCKS     = 4,
  parameter int PAGES_PER_BLK  = 32,
  parameter int WORDS_PER_PAGE = 4,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLK),
  localparam int WD_W  = $clog2(WORDS_PER_PAGE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic [PG_W-1:0]  cmd_page,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic             rd_valid,
  input  logic             rd_ready,
  input  logic             blk_worn,
  input  logic             page_written,
  output logic             erase_en,
  output logic             word_we,
  output logic             mark_en,
  output logic [BLK_W-1:0] blk_q,
  output logic [PG_W-1:0]  page_q,
  output logic [WD_W-1:0]  idx_q,
  output logic             done,
  output logic [1:0]       done_status
);
  flash_state_e  state_q, state_n;
  flash_status_e stat_q, stat_n;
  logic          done_q, done_n;
  logic [WD_W-1:0] idx_n;
  logic          accept, idx_en, last_word;

  assign accept    = (state_q == FS_IDLE) && cmd_valid;
  assign last_word = (idx_q == WD_W'(WORDS_PER_PAGE - 1));

  always_comb begin
    state_n  = state_q;
    stat_n   = stat_q;
    done_n   = 1'b0;
    idx_n    = idx_q;
    idx_en   = 1'b0;
    erase_en = 1'b0;
    word_we  = 1'b0;
    mark_en  = 1'b0;
    unique case (state_q)
      FS_IDLE: if (accept) begin
        idx_n  = '0;
        idx_en = 1'b1;
        if (blk_worn) begin
          done_n = 1'b1;
          stat_n = ST_WORN;
        end else if (cmd_op[1]) begin
          erase_en = 1'b1;
          done_n   = 1'b1;
          stat_n   = ST_OK;
        end else if (cmd_op[0]) begin
          if (page_written) begin
            done_n = 1'b1;
            stat_n = ST_REWRITE;
          end else begin
            state_n = FS_WRITE;
          end
        end else begin
          state_n = FS_READ;
        end
      end
      FS_WRITE: if (wr_valid) begin
        word_we = 1'b1;
        idx_n   = idx_q + 1'b1;
        idx_en  = 1'b1;
        if (last_word) begin
          mark_en = 1'b1;
          done_n  = 1'b1;
          stat_n  = ST_OK;
          state_n = FS_IDLE;
        end
      end
      FS_READ: if (rd_ready) begin
        idx_n  = idx_q + 1'b1;
        idx_en = 1'b1;
        if (last_word) begin
          done_n  = 1'b1;
          stat_n  = ST_OK;
          state_n = FS_IDLE;
        end
      end
      default: state_n = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      stat_q  <= ST_OK;
      done_q  <= 1'b0;
      idx_q   <= '0;
      blk_q   <= '0;
      page_q  <= '0;
    end else begin
      state_q <= state_n;
      stat_q  <= stat_n;
      done_q  <= done_n;
      if (idx_en) idx_q <= idx_n;
      if (accept) begin
        blk_q  <= cmd_blk;
        page_q <= cmd_page;
      end
    end
  end

  assign cmd_ready   = (state_q == FS_IDLE);
  assign wr_ready    = (state_q == FS_WRITE);
  assign rd_valid    = (state_q == FS_READ);
  assign done        = done_q;
  assign done_status = stat_q;
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int NUM_BLOCKS     = 4,
  parameter int PAGES_PER_BLK  = 32,
  parameter int WORDS_PER_PAGE = 4,
  parameter int DATA_W         = 16,
  parameter int WEAR_LIMIT     = 100000,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLK),
  localparam int WD_W  = $clog2(WORDS_PER_PAGE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [BLK_W-1:0]  cmd_blk,
  input  logic [PG_W-1:0]   cmd_page,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [1:0]        done_status
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             blk_worn, page_written;
  logic             erase_en, word_we, mark_en;
  logic [BLK_W-1:0] blk_q;
  logic [PG_W-1:0]  page_q;
  logic [WD_W-1:0]  idx_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  flash_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLK(PAGES_PER_BLK),
    .WORDS_PER_PAGE(WORDS_PER_PAGE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_core_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_blk(cmd_blk), .cmd_page(cmd_page),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .blk_worn(blk_worn), .page_written(page_written),
    .erase_en(erase_en), .word_we(word_we), .mark_en(mark_en),
    .blk_q(blk_q), .page_q(page_q), .idx_q(idx_q),
    .done(done), .done_status(done_status)
  );

  flash_page_store #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLK(PAGES_PER_BLK),
    .WORDS_PER_PAGE(WORDS_PER_PAGE), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_core_n),
    .erase_en(erase_en), .erase_blk(cmd_blk),
    .word_we(word_we), .mark_en(mark_en),
    .acc_blk(blk_q), .acc_page(page_q), .acc_word(idx_q),
    .wdata(wr_data), .rdata(rd_data),
    .q_blk(cmd_blk), .q_page(cmd_page), .q_written(page_written)
  );

  flash_wear_table #(
    .NUM_BLOCKS(NUM_BLOCKS), .WEAR_LIMIT(WEAR_LIMIT)
  ) u_wear (
    .clk(clk), .rst_n(rst_core_n),
    .inc_en(erase_en), .inc_blk(cmd_blk),
    .q_blk(cmd_blk), .q_worn(blk_worn)
  );
endmodule

// File: rtl/flash_array_chk.sv
module flash_array_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              done,
  input logic [1:0]        done_status
);
  // R1
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!wr_ready && !rd_valid));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R8
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_status != 2'b11));

  // R5
  reject_no_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status == 2'b01) |-> !wr_ready);

  // R7
  worn_no_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status == 2'b10) |-> (!wr_ready && !rd_valid));
endmodule

bind flash_array flash_array_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .done(done), .done_status(done_status)
);

// File: tb/flash_array_test.sv
module flash_array_test;
  localparam int NB = 4, PPB = 32, WPP = 4, DW = 16, LIM = 3;
  localparam int BW = $clog2(NB), PW = $clog2(PPB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, wr_valid = 1'b0, rd_ready = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [BW-1:0] cmd_blk = '0;
  logic [PW-1:0] cmd_page = '0;
  logic [DW-1:0] wr_data = '0;
  logic cmd_ready, wr_ready, rd_valid, done;
  logic [DW-1:0] rd_data;
  logic [1:0] done_status;

  int checks = 0, errors = 0;

  logic [DW-1:0] m_data [NB][PPB][WPP];
  bit            m_wr [NB][PPB];
  int            m_cnt [NB];

  always #10 clk = ~clk;

  flash_array #(.NUM_BLOCKS(NB), .PAGES_PER_BLK(PPB), .WORDS_PER_PAGE(WPP),
                .DATA_W(DW), .WEAR_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_page(cmd_page),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .done_status(done_status));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_status(input logic [1:0] op, input int b, input int p);
    if (m_cnt[b] >= LIM) return 2'b10;
    if (!op[1] && op[0] && m_wr[b][p]) return 2'b01;
    return 2'b00;
  endfunction

  function automatic void model_erase(input int b);
    for (int p = 0; p < PPB; p++) begin
      m_wr[b][p] = 1'b0;
      for (int w = 0; w < WPP; w++) m_data[b][p][w] = '1;
    end
    m_cnt[b]++;
  endfunction

  // called at the negedge after acceptance
  task automatic stream_write(input int b, input int p);
    int k = 0;
    while (k < WPP) begin
      wr_valid = ($urandom % 4) != 0;
      wr_data  = DW'($urandom);
      if (wr_valid && wr_ready) begin
        m_data[b][p][k] = wr_data;
        k++;
      end
      @(negedge clk);
    end
    wr_valid = 1'b0;
    m_wr[b][p] = 1'b1;
  endtask

  task automatic stream_read(input int b, input int p);
    int k = 0;
    chk(rd_valid === 1'b1, "R3 read stream open", rd_valid, 1);
    while (k < WPP) begin
      rd_ready = ($urandom % 3) != 0;
      if (rd_valid && rd_ready) begin
        chk(rd_data === m_data[b][p][k], "R3 read word", rd_data, m_data[b][p][k]);
        k++;
      end
      @(negedge clk);
    end
    rd_ready = 1'b0;
  endtask

  task automatic run_cmd(input logic [1:0] op, input int b, input int p);
    logic [1:0] es = exp_status(op, b, p);
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R1 ready when idle", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_blk = BW'(b); cmd_page = PW'(p);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (es == 2'b00 && !op[1] && op[0]) begin
      chk(wr_ready === 1'b1, "R2 write stream open", wr_ready, 1);
      stream_write(b, p);
    end else if (es == 2'b00 && op == 2'b00) begin
      stream_read(b, p);
    end else begin
      if (es == 2'b00) model_erase(b);
      if (es == 2'b01) chk(wr_ready === 1'b0, "R5 no words taken", wr_ready, 0);
      if (es == 2'b10) chk(!wr_ready && !rd_valid, "R7 no stream on worn", {wr_ready, rd_valid}, 0);
    end
    chk(done === 1'b1 && done_status === es, "R8 done and status", {done, done_status}, {1'b1, es});
    @(negedge clk);
    chk(done === 1'b0, "R8 single pulse", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int b = 0; b < NB; b++) begin
      m_cnt[b] = 0;
      for (int p = 0; p < PPB; p++) m_wr[b][p] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(done === 1'b0 && cmd_ready === 1'b1 && !wr_ready && !rd_valid,
        "R10 reset state", {done, cmd_ready, wr_ready, rd_valid}, 4'b0100);

    for (int b = 0; b < NB; b++) run_cmd(2'b10, b, 0);        // R4 initial erase
    run_cmd(2'b00, 2, 7);                                      // R4 erased reads ones
    run_cmd(2'b01, 0, 3);                                      // R2 program
    run_cmd(2'b00, 0, 3);                                      // R2 read back
    run_cmd(2'b01, 0, 3);                                      // R5 rewrite rejected
    run_cmd(2'b00, 0, 3);                                      // R5 data unchanged
    run_cmd(2'b01, 1, 5);
    run_cmd(2'b11, 0, 0);                                      // R4 erase code 1x
    run_cmd(2'b00, 1, 5);                                      // R4 other block kept
    run_cmd(2'b00, 0, 3);                                      // R4 erased block ones
    run_cmd(2'b01, 0, 3);                                      // R4 reprogram allowed

    // R9 back-to-back: read accepted in the done cycle of an erase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_blk = 1; cmd_page = 0;
    @(negedge clk);
    chk(done === 1'b1 && done_status === 2'b00 && cmd_ready === 1'b1,
        "R9 erase done with ready", {done, done_status, cmd_ready}, 4'b1001);
    model_erase(1);
    cmd_op = 2'b00; cmd_blk = 1; cmd_page = 5;
    @(negedge clk);
    cmd_valid = 1'b0;
    stream_read(1, 5);
    chk(done === 1'b1 && done_status === 2'b00, "R9 second pulse", {done, done_status}, 4);

    // R6 / R7 wear out block 3 (count is 1 already)
    run_cmd(2'b10, 3, 0);
    run_cmd(2'b01, 3, 9);
    run_cmd(2'b10, 3, 0);                                      // R6 reaches limit, OK
    run_cmd(2'b10, 3, 0);                                      // R7 worn
    run_cmd(2'b01, 3, 4);                                      // R7 worn program
    run_cmd(2'b00, 3, 9);                                      // R7 worn read

    // random traffic on a few pages
    for (int n = 0; n < 250; n++) begin
      int r = $urandom % 20;
      logic [1:0] op = (r < 2) ? 2'b10 : (r < 11) ? 2'b01 : 2'b00;
      run_cmd(op, $urandom % NB, $urandom % 4);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule